// File: doc/BRIEF.md
# Framed SPI Register-Read Master

This block reads one or more consecutive registers from a peripheral over SPI using a fixed framing. On a start request it lowers chip select, shifts out a 32-bit header, then keeps clocking for eight SCLK pulses per requested byte. The header holds the 16-bit register address followed by a 16-bit control word with a read opcode and the byte count. While the peripheral returns data the master sends zero bytes on MOSI. Chip select stays low for the whole frame.

The user side gives a single-cycle start, an address and a length. Each byte received on MISO comes back on a byte output with a one-cycle valid strobe. A one-cycle done pulse marks the end of the frame. The SCLK rate, the delay between chip select falling and the first clock, and the delay between the last clock and chip select rising are parameters counted in SCLK half-periods.

Top module: `spi_regrd_master`

## Requirements
- R1: During and after reset, until a request is accepted, `cs_n` is 1 and `sclk`, `busy`, `rx_valid` and `done` are 0.
- R2: The first 32 bits sent on MOSI are, most significant first: the 16-bit address in bits 31:16, the read opcode value 0 in bit 15, and the 15-bit length in bits 14:0.
- R3: A frame has exactly 32 + 8×length rising SCLK edges (SPI mode 0). SCLK is low whenever chip select is high, and MOSI never changes while SCLK is high.
- R4: After the 32 header bits, MOSI is 0 at every rising SCLK edge of the data phase.
- R5: `cs_n` falls once and rises once per frame, with no rise between bytes. `cs_n` is low only while `busy` is 1.
- R6: At least SETUP_HALVES×DIV_HALF clock cycles pass between the fall of `cs_n` and the first rising SCLK edge.
- R7: At least DIV_HALF clock cycles pass between the last falling SCLK edge and the rise of `cs_n`.
- R8: Each group of 8 data bits, sampled from MISO on rising SCLK edges with the most significant bit first, appears on `rx_data` with a one-cycle `rx_valid`. Exactly `length` bytes are delivered. A read of address 0x001F from the model peripheral returns 0x03.
- R9: `done` is a one-cycle pulse in the same cycle that `cs_n` returns high, after the last byte.
- R10: A start request with a length of 0 is ignored: no frame begins and `busy` stays 0.
- R11: A start request while `busy` is 1 is ignored. The frame in progress keeps its address and length, and no second frame follows.
- R12: `rx_valid` is never 1 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| addr | input | 16 | Register address of the first byte |
| len | input | 15 | Number of bytes to read |
| busy | output | 1 | Frame in progress |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| done | output | 1 | One-cycle end-of-frame pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The properties assume that `start` and `len` are valid, two-state levels on every clock edge. They also assume that `miso` is settled by the time the master samples it on the clock edge that raises SCLK. The peripheral model in the bench meets this by changing MISO only on falling SCLK edges and holding it high while chip select is high. The stimulus pulses `start` for a single cycle and uses lengths of up to four bytes. It deliberately issues a zero-length request and a request in the middle of a frame, so that the ignore paths are exercised.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int ADDR_W   = 16;
  localparam int LEN_W    = 15;
  localparam int HDR_BITS = ADDR_W + 1 + LEN_W;
  localparam logic OP_READ = 1'b0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_HOLD  = 2'd3
  } st_e;
endpackage

// File: rtl/spi_rd_rst_sync.sv
module spi_rd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/spi_rd_fsm.sv
module spi_rd_fsm
  import spi_rd_pkg::*;
#(
  parameter int SETUP_HALVES = 2,
  parameter int HOLD_HALVES  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  output logic             run,
  output logic             load,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             byte_end,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             done
);
  localparam int BW   = LEN_W + 4;
  localparam int DMAX = (SETUP_HALVES > HOLD_HALVES) ? SETUP_HALVES : HOLD_HALVES;
  localparam int DW   = $clog2(DMAX + 1);
  localparam logic [DW-1:0] SETUP_LAST = DW'(SETUP_HALVES - 1);
  localparam logic [DW-1:0] HOLD_LAST  = DW'(HOLD_HALVES - 1);
  localparam logic [BW-1:0] HDR_LAST   = BW'(HDR_BITS - 1);
  localparam logic [BW-1:0] HDR_FIRST  = BW'(HDR_BITS);

  st_e             state_q, state_d;
  logic            sclk_q, sclk_d;
  logic            cs_q, cs_d;
  logic            done_q, done_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [BW-1:0]   last_q, last_d;
  logic [DW-1:0]   dly_q, dly_d;
  logic            accept;

  assign accept   = (state_q == ST_IDLE) && start && (len != '0);
  assign load     = accept;
  assign run      = (state_q != ST_IDLE);
  assign rise_evt = (state_q == ST_XFER) && tick && !sclk_q;
  assign fall_evt = (state_q == ST_XFER) && tick && sclk_q;
  assign byte_end = rise_evt && (bit_q >= HDR_FIRST) && (bit_q[2:0] == 3'b111);

  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    done_d  = 1'b0;
    bit_d   = bit_q;
    last_d  = last_q;
    dly_d   = dly_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SETUP;
          cs_d    = 1'b0;
          bit_d   = '0;
          dly_d   = '0;
          last_d  = BW'({len, 3'b000}) + HDR_LAST;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          if (dly_q == SETUP_LAST) state_d = ST_XFER;
          else                     dly_d   = dly_q + DW'(1);
        end
      end
      ST_XFER: begin
        if (rise_evt) sclk_d = 1'b1;
        if (fall_evt) begin
          sclk_d = 1'b0;
          if (bit_q == last_q) begin
            state_d = ST_HOLD;
            dly_d   = '0;
          end else begin
            bit_d = bit_q + BW'(1);
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          if (dly_q == HOLD_LAST) begin
            state_d = ST_IDLE;
            cs_d    = 1'b1;
            done_d  = 1'b1;
          end else begin
            dly_d = dly_q + DW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      bit_q   <= '0;
      last_q  <= '0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
      dly_q   <= dly_d;
    end
  end

  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign busy = run;
  assign done = done_q;
endmodule

// File: rtl/spi_rd_shift.sv
module spi_rd_shift
  import spi_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              byte_end,
  input  logic              miso,
  output logic              mosi,
  output logic [7:0]        rx_data,
  output logic              rx_valid
);
  logic [HDR_BITS-1:0] tx_q, tx_d;
  logic [7:0]          rx_q, rx_d;
  logic [7:0]          dat_q, dat_d;
  logic                vld_q, vld_d;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    dat_d = dat_q;
    vld_d = byte_end;
    if (load)          tx_d = {addr, OP_READ, len};
    else if (fall_evt) tx_d = {tx_q[HDR_BITS-2:0], 1'b0};
    if (rise_evt)      rx_d = {rx_q[6:0], miso};
    if (byte_end)      dat_d = {rx_q[6:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign mosi     = tx_q[HDR_BITS-1];
  assign rx_data  = dat_q;
  assign rx_valid = vld_q;
endmodule

// File: rtl/spi_regrd_master.sv
module spi_regrd_master
  import spi_rd_pkg::*;
#(
  parameter int DIV_HALF     = 2,
  parameter int SETUP_HALVES = 2,
  parameter int HOLD_HALVES  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic rst_sync_n;
  logic run, tick, load, rise_evt, fall_evt, byte_end;

  spi_rd_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  spi_rd_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick)
  );

  spi_rd_fsm #(
    .SETUP_HALVES (SETUP_HALVES),
    .HOLD_HALVES  (HOLD_HALVES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .len      (len),
    .tick     (tick),
    .run      (run),
    .load     (load),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .byte_end (byte_end),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .busy     (busy),
    .done     (done)
  );

  spi_rd_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .addr     (addr),
    .len      (len),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .byte_end (byte_end),
    .miso     (miso),
    .mosi     (mosi),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );
endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker
  import spi_rd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] len,
  input logic             busy,
  input logic             rx_valid,
  input logic             done,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi
);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  p_cs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (len == '0)) |=> !busy);

  p_valid_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);
endmodule

bind spi_regrd_master spi_rd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .len      (len),
  .busy     (busy),
  .rx_valid (rx_valid),
  .done     (done),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi)
);

// File: tb/spi_regrd_master_test.sv
module spi_regrd_master_test;
  localparam int DIV_HALF     = 2;
  localparam int SETUP_HALVES = 2;
  localparam int HOLD_HALVES  = 1;
  localparam int NV = 5;
  localparam logic [30:0] VEC [NV] = '{
    {16'h001F, 15'd1},
    {16'h000F, 15'd4},
    {16'hA5C3, 15'd2},
    {16'hFFFE, 15'd3},
    {16'h0100, 15'd1}
  };

  logic        clk, rst_n, start, miso;
  logic [15:0] addr;
  logic [14:0] len;
  logic        busy, rx_valid, done, cs_n, sclk, mosi;
  logic [7:0]  rx_data;

  int checks, errs;
  int nrx, stray, sclk_rises, cs_falls, cs_rises, done_cnt, done_at_rise;
  int setup_meas, hold_meas, cnt_cs, cnt_fall;
  int mosi_err, scnt;
  logic        prev_cs, prev_sclk, miso_r;
  logic [31:0] s_hdr;
  logic [7:0]  rxbuf [16];

  spi_regrd_master #(
    .DIV_HALF(DIV_HALF), .SETUP_HALVES(SETUP_HALVES), .HOLD_HALVES(HOLD_HALVES)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .len(len),
    .busy(busy), .rx_data(rx_data), .rx_valid(rx_valid), .done(done),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] reg_val(input logic [15:0] a);
    if (a == 16'h001F) return 8'h03;
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // peripheral model: drives MISO only while selected, idle high otherwise
  assign miso = cs_n ? 1'b1 : miso_r;

  always @(negedge cs_n) begin
    scnt   = 0;
    s_hdr  = '0;
    miso_r = 1'b0;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      if (scnt < 32) s_hdr = {s_hdr[30:0], mosi};
      else if (mosi !== 1'b0) mosi_err++;
      scnt++;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && scnt >= 32) begin
      automatic int idx = scnt - 32;
      automatic logic [7:0] b = reg_val(s_hdr[31:16] + 16'(idx / 8));
      miso_r = b[7 - (idx % 8)];
    end
  end

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rx_valid) begin
      if (cs_n) stray++;
      else begin
        if (nrx < 16) rxbuf[nrx] = rx_data;
        nrx++;
      end
    end
    if (prev_cs && !cs_n) begin cs_falls++; cnt_cs = 0; end
    else cnt_cs++;
    if (prev_sclk && !sclk) cnt_fall = 0;
    else cnt_fall++;
    if (!prev_sclk && sclk) begin
      if (sclk_rises == 0) setup_meas = cnt_cs;
      sclk_rises++;
    end
    if (!prev_cs && cs_n) begin
      cs_rises++;
      hold_meas = cnt_fall;
      if (done) done_at_rise++;
    end
    if (done) done_cnt++;
    prev_cs   = cs_n;
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    nrx = 0; sclk_rises = 0; cs_falls = 0; cs_rises = 0; done_cnt = 0;
    done_at_rise = 0; setup_meas = 0; hold_meas = 0; mosi_err = 0;
  endtask

  task automatic issue(input logic [15:0] a, input logic [14:0] l);
    @(negedge clk);
    addr = a; len = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_cnt == 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input logic [15:0] a, input logic [14:0] l);
    int n = int'(l);
    check(s_hdr[31:16] == a, "R2 address", int'(s_hdr[31:16]), int'(a));
    check(s_hdr[15] == 1'b0, "R2 opcode", int'(s_hdr[15]), 0);
    check(s_hdr[14:0] == l, "R2 length", int'(s_hdr[14:0]), n);
    check(sclk_rises == 32 + 8 * n, "R3 sclk edges", sclk_rises, 32 + 8 * n);
    check(mosi_err == 0, "R4 dummy zeros", mosi_err, 0);
    check(cs_falls == 1 && cs_rises == 1, "R5 cs edges", cs_falls * 10 + cs_rises, 11);
    check(setup_meas >= SETUP_HALVES * DIV_HALF, "R6 setup", setup_meas, SETUP_HALVES * DIV_HALF);
    check(hold_meas >= DIV_HALF, "R7 hold", hold_meas, DIV_HALF);
    check(nrx == n, "R8 byte count", nrx, n);
    for (int i = 0; i < n && i < 16; i++) begin
      automatic logic [7:0] e = reg_val(a + 16'(i));
      check(rxbuf[i] == e, "R8 byte value", int'(rxbuf[i]), int'(e));
    end
    check(done_cnt == 1 && done_at_rise == 1, "R9 done", done_cnt * 10 + done_at_rise, 11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    checks = 0; errs = 0; stray = 0; scnt = 0; miso_r = 1'b0; s_hdr = '0;
    cnt_cs = 0; cnt_fall = 0; prev_cs = 1'b1; prev_sclk = 1'b0;
    clear_stats();
    start = 1'b0; addr = '0; len = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check(cs_n && !sclk && !busy && !rx_valid && !done, "R1 in reset",
          {cs_n, sclk, busy, rx_valid, done}, 5'b10000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(cs_n && !sclk && !busy && !rx_valid && !done, "R1 after reset",
          {cs_n, sclk, busy, rx_valid, done}, 5'b10000);

    // table-driven frames
    for (int i = 0; i < NV; i++) begin
      clear_stats();
      issue(VEC[i][30:15], VEC[i][14:0]);
      wait_done();
      check_frame(VEC[i][30:15], VEC[i][14:0]);
    end

    // R8 identity read of 0x001F
    clear_stats();
    issue(16'h001F, 15'd1);
    wait_done();
    check(nrx == 1 && rxbuf[0] == 8'h03, "R8 identity", int'(rxbuf[0]), 3);

    // R10: zero length ignored
    clear_stats();
    issue(16'h0042, 15'd0);
    repeat (30) @(negedge clk);
    check(!busy && cs_falls == 0, "R10 zero length", cs_falls, 0);

    // R11: start while busy ignored
    clear_stats();
    issue(16'h001F, 15'd1);
    repeat (30) @(negedge clk);
    issue(16'h5555, 15'd2);
    wait_done();
    repeat (60) @(negedge clk);
    check(s_hdr[31:16] == 16'h001F, "R11 address kept", int'(s_hdr[31:16]), 16'h001F);
    check(nrx == 1 && cs_falls == 1 && done_cnt == 1, "R11 single frame",
          nrx * 100 + cs_falls * 10 + done_cnt, 111);

    // R12: no byte strobe while deselected
    check(stray == 0, "R12 stray valid", stray, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule